// File: doc/BRIEF.md
# Packed Lane Left Shifter with Sticky Overflow

This unit shifts a 32-bit word left, one lane at a time. The word is split into four 8-bit lanes or into two 16-bit lanes, chosen per operation. All lanes use the same shift amount. Bits pushed out of the top of a lane are dropped. Each lane fills with zeros from the right, and no lane passes bits to its neighbour. The shifted word is registered and appears one cycle after the operation is accepted.

Each lane also checks whether the shift lost significant information. The check differs by lane mode:

- 8-bit lanes are checked as unsigned values.
- 16-bit lanes are checked as signed values. Every bit that moves across or into the sign position must equal the original sign.

If any lane of an accepted operation overflows, a sticky flag is set at a fixed position in a 32-bit status word. The flag stays set until software writes the status word through the write port. Such a write has priority over an operation in the same cycle, and that operation's overflow is then applied on top of the written value.

Top module: `simd_lshift_unit`

## Requirements
- R1: With `lane_mode` = 0 (8-bit lanes), each byte of `operand` is shifted left by `shamt[2:0]`, zero-filled from the right, with the excess bits dropped. `shamt[3]` has no effect in this mode.
- R2: With `lane_mode` = 1 (16-bit lanes), each halfword of `operand` is shifted left by `shamt[3:0]`, zero-filled, with the excess bits dropped. There is no saturation.
- R3: In 8-bit mode with shift s > 0, a lane overflows when any of its top s bits (bits 7 down to 8-s) is 1.
- R4: In 16-bit mode with shift s > 0, a lane overflows unless its bits 15 down to 15-s all hold the same value.
- R5: A shift amount of zero, as seen by the selected mode, returns the operand unchanged and never overflows.
- R6: An accepted operation (`op_valid` = 1) in which any lane overflows sets `status[22]` at the next clock edge. The bit then stays set until a status write.
- R7: When `stat_we` = 1, `status` takes `stat_wdata` at the next edge. If an operation that overflows is accepted in the same cycle, bit 22 is set on top of the written value.
- R8: `result` updates one cycle after an operation with `op_valid` = 1 and holds otherwise. When `op_valid` = 0, the operand has no effect on `status`.
- R9: After reset, `result` and `status` are both zero.
- R10: Status bits other than bit 22 change only through a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Accept an operation this cycle |
| lane_mode | input | 1 | 0 = four 8-bit lanes, 1 = two 16-bit lanes |
| shamt | input | 4 | Shift amount; only bits [2:0] are used in 8-bit mode |
| operand | input | 32 | Packed input word |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 32 | Value to write into the status word |
| result | output | 32 | Registered shifted word |
| status | output | 32 | Status word; bit 22 is the sticky overflow flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 8-bit narrow lanes, 16-bit wide lanes, and the flag at bit 22 of a 32-bit status word. These values cover every shift amount in both lane modes, including the extremes of 7 and 15. They also cover the sign-crossing case that separates the unsigned check from the signed one.

Random status writes are mixed with operations, so same-cycle write-plus-overflow conflicts occur often. Random writes also place values in the non-flag status bits, where any change caused by an operation would show up.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;
  typedef enum logic {
    LANES_NARROW = 1'b0,
    LANES_WIDE   = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/simd_lane_shl.sv
module simd_lane_shl #(
  parameter int LANE_W     = 8,
  parameter bit SIGNED_CHK = 1'b0,
  localparam int SH_W      = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [SH_W-1:0]   sh,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_ovf
);
  localparam int EXT_W = 2 * LANE_W;

  // Place the lane in a double-width field (sign- or zero-extended), then shift.
  function automatic logic [EXT_W-1:0] widen_shift(input logic [LANE_W-1:0] a,
                                                   input logic [SH_W-1:0]   s,
                                                   input logic              sext);
    logic [EXT_W-1:0] e;
    e = {{LANE_W{sext & a[LANE_W-1]}}, a};
    return e << s;
  endfunction

  logic [EXT_W-1:0] ext;

  generate
    if (SIGNED_CHK) begin : g_signed
      logic [LANE_W:0] upper;
      always_comb begin
        ext      = widen_shift(lane_in, sh, 1'b1);
        upper    = ext[EXT_W-1:LANE_W-1];
        lane_ovf = !((&upper) || !(|upper));
      end
    end else begin : g_unsigned
      always_comb begin
        ext      = widen_shift(lane_in, sh, 1'b0);
        lane_ovf = |ext[EXT_W-1:LANE_W];
      end
    end
  endgenerate

  assign lane_out = ext[LANE_W-1:0];
endmodule

// File: rtl/simd_shl_datapath.sv
module simd_shl_datapath
  import simd_shl_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8,
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int AMT_W   = $clog2(WIDE_W)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [AMT_W-1:0]  amt,
  input  lane_mode_e        mode,
  output logic [WORD_W-1:0] word_out,
  output logic              any_ovf
);
  localparam int N_NARROW = WORD_W / NARROW_W;
  localparam int N_WIDE   = WORD_W / WIDE_W;
  localparam int NSH_W    = $clog2(NARROW_W);

  logic [WORD_W-1:0]   narrow_word, wide_word;
  logic [N_NARROW-1:0] narrow_ovf;
  logic [N_WIDE-1:0]   wide_ovf;

  genvar gi;
  generate
    for (gi = 0; gi < N_NARROW; gi++) begin : g_narrow
      simd_lane_shl #(.LANE_W(NARROW_W), .SIGNED_CHK(1'b0)) u_lane (
        .lane_in  (word_in[gi*NARROW_W +: NARROW_W]),
        .sh       (amt[NSH_W-1:0]),
        .lane_out (narrow_word[gi*NARROW_W +: NARROW_W]),
        .lane_ovf (narrow_ovf[gi])
      );
    end
    for (gi = 0; gi < N_WIDE; gi++) begin : g_wide
      simd_lane_shl #(.LANE_W(WIDE_W), .SIGNED_CHK(1'b1)) u_lane (
        .lane_in  (word_in[gi*WIDE_W +: WIDE_W]),
        .sh       (amt),
        .lane_out (wide_word[gi*WIDE_W +: WIDE_W]),
        .lane_ovf (wide_ovf[gi])
      );
    end
  endgenerate

  always_comb begin
    if (mode == LANES_WIDE) begin
      word_out = wide_word;
      any_ovf  = |wide_ovf;
    end else begin
      word_out = narrow_word;
      any_ovf  = |narrow_ovf;
    end
  end
endmodule

// File: rtl/simd_status_reg.sv
module simd_status_reg #(
  parameter int STATUS_W = 32,
  parameter int OVF_POS  = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [STATUS_W-1:0] wr_data,
  input  logic                set_ovf,
  output logic [STATUS_W-1:0] stat_q
);
  localparam logic [STATUS_W-1:0] FLAG_MASK = STATUS_W'(1) << OVF_POS;

  logic [STATUS_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en)   stat_d = wr_data;
    if (set_ovf) stat_d[OVF_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R6
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> stat_q[OVF_POS]);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[OVF_POS] && !wr_en) |=> stat_q[OVF_POS]);
  // R7
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_ovf) |=> (stat_q == $past(wr_data)));
  // R10
  other_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat_q & ~FLAG_MASK) == ($past(stat_q) & ~FLAG_MASK)));
endmodule

// File: rtl/simd_lshift_unit.sv
module simd_lshift_unit
  import simd_shl_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8,
  parameter int STATUS_W = 32,
  parameter int OVF_POS  = 22,
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int AMT_W   = $clog2(WIDE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                lane_mode,
  input  logic [AMT_W-1:0]    shamt,
  input  logic [WORD_W-1:0]   operand,
  input  logic                stat_we,
  input  logic [STATUS_W-1:0] stat_wdata,
  output logic [WORD_W-1:0]   result,
  output logic [STATUS_W-1:0] status
);
  localparam int NSH_W = $clog2(NARROW_W);

  lane_mode_e        mode;
  logic [WORD_W-1:0] shifted;
  logic              dp_ovf;
  logic              op_ovf;
  logic              eff_amt_zero;

  assign mode   = lane_mode_e'(lane_mode);
  assign op_ovf = op_valid & dp_ovf;
  assign eff_amt_zero = (mode == LANES_WIDE) ? (shamt == '0)
                                             : (shamt[NSH_W-1:0] == '0);

  simd_shl_datapath #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_dp (
    .word_in  (operand),
    .amt      (shamt),
    .mode     (mode),
    .word_out (shifted),
    .any_ovf  (dp_ovf)
  );

  simd_status_reg #(.STATUS_W(STATUS_W), .OVF_POS(OVF_POS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (stat_we),
    .wr_data (stat_wdata),
    .set_ovf (op_ovf),
    .stat_q  (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= '0;
    else if (op_valid) result <= shifted;
  end

  // R5
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && eff_amt_zero) |-> (!dp_ovf && shifted == operand));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result));
  // R8
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !stat_we) |=> $stable(status));
endmodule

// File: tb/tb_simd_lshift_unit.sv
`timescale 1ns/1ps
module tb_simd_lshift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        lane_mode = 1'b0;
  logic [3:0]  shamt = '0;
  logic [31:0] operand = '0;
  logic        stat_we = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] result;
  logic [31:0] status;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] m_res = '0;
  logic [31:0] m_stat = '0;

  always #2.5 clk = ~clk;

  simd_lshift_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lane_mode(lane_mode),
    .shamt(shamt), .operand(operand), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .result(result), .status(status)
  );

  function automatic logic [31:0] ref_shift(logic wide, logic [3:0] amt, logic [31:0] x);
    int lw = wide ? 16 : 8;
    int s  = wide ? int'(amt) : int'(amt[2:0]);
    logic [31:0] r = '0;
    for (int base = 0; base < 32; base += lw)
      for (int i = 0; i < lw; i++)
        if (i >= s) r[base+i] = x[base+i-s];
    return r;
  endfunction

  function automatic logic ref_ovf(logic wide, logic [3:0] amt, logic [31:0] x);
    logic o = 1'b0;
    if (!wide) begin
      int s = int'(amt[2:0]);
      for (int base = 0; base < 32; base += 8)
        for (int i = 8 - s; i < 8; i++)
          if (x[base+i]) o = 1'b1;
    end else begin
      int s = int'(amt);
      for (int base = 0; base < 32; base += 16)
        for (int i = 15 - s; i < 15; i++)
          if (x[base+i] != x[base+15]) o = 1'b1;
    end
    return o;
  endfunction

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // Inputs are driven just after a falling edge; outputs are sampled at the next falling edge.
  task automatic step(logic v, logic md, logic [3:0] a, logic [31:0] x,
                      logic we, logic [31:0] wd, string req);
    op_valid = v; lane_mode = md; shamt = a; operand = x;
    stat_we = we; stat_wdata = wd;
    if (v) m_res = ref_shift(md, a, x);
    if (we) m_stat = wd;
    if (v && ref_ovf(md, a, x)) m_stat[22] = 1'b1;
    @(negedge clk);
    check_eq(req, "result", result, m_res);
    check_eq(req, "status", status, m_stat);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240501));
    repeat (3) @(negedge clk);
    check_eq("R9", "result", result, 32'h0);
    check_eq("R9", "status", status, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9", "status", status, 32'h0);

    // R2 R4: sign crossing by one, result truncated without saturation
    step(1, 1, 4'd1, 32'h7FFF8000, 1, 32'h0, "R4");
    check_eq("R2", "directed", result, 32'hFFFE0000);
    check_eq("R4", "flag", {31'h0, status[22]}, 32'h1);
    // R4: a one pushed into the sign position at the largest shift
    step(1, 1, 4'd15, 32'h00000001, 1, 32'h0, "R4");
    check_eq("R4", "directed", result, 32'h00008000);
    check_eq("R4", "flag", {31'h0, status[22]}, 32'h1);
    // R3: unsigned bytes, a one reaching bit 7 is not lost
    step(1, 0, 4'd7, 32'h00000001, 1, 32'h0, "R3");
    check_eq("R3", "directed", result, 32'h00000080);
    check_eq("R3", "flag", {31'h0, status[22]}, 32'h0);
    // R1 R3: per-byte shift by 3 with bits lost
    step(1, 0, 4'd3, 32'h87654321, 1, 32'h0, "R3");
    check_eq("R1", "directed", result, 32'h38281808);
    check_eq("R3", "flag", {31'h0, status[22]}, 32'h1);
    // R1: shamt[3] ignored in byte mode (11 acts as 3)
    step(1, 0, 4'b1011, 32'h01020408, 1, 32'h0, "R1");
    check_eq("R1", "upper amt bit", result, 32'h08102040);
    // R5: zero shift in both modes, negative values, no flag
    step(1, 1, 4'd0, 32'h8001FFFF, 1, 32'h0, "R5");
    check_eq("R5", "flag", {31'h0, status[22]}, 32'h0);
    step(1, 0, 4'b1000, 32'hFF80FF01, 0, 32'h0, "R5");
    check_eq("R5", "flag", {31'h0, status[22]}, 32'h0);
    // R6: flag sticks across non-overflowing operations
    step(1, 0, 4'd4, 32'hF0000000, 0, 32'h0, "R6");
    step(1, 0, 4'd1, 32'h01010101, 0, 32'h0, "R6");
    check_eq("R6", "sticky", {31'h0, status[22]}, 32'h1);
    // R8: idle cycle with an overflowing operand touches nothing
    step(1, 1, 4'd2, 32'h00010001, 1, 32'h0, "R8");
    step(0, 0, 4'd7, 32'hFFFFFFFF, 0, 32'h0, "R8");
    check_eq("R8", "idle status", status, 32'h0);
    check_eq("R8", "idle result", result, 32'h00040004);
    // R7: write and overflow in one cycle, flag lands on written value
    step(1, 0, 4'd5, 32'h80000000, 1, 32'h00A00001, "R7");
    check_eq("R7", "write+ovf", status, 32'h00E00001);
    // R10: other bits survive operations
    step(1, 1, 4'd8, 32'h12345678, 0, 32'h0, "R10");
    check_eq("R10", "other bits", status & 32'hFFBFFFFF, 32'h00A00001);
    // R7: write clears flag when the same-cycle operation is clean
    step(1, 1, 4'd1, 32'h00010001, 1, 32'h0, "R7");
    check_eq("R7", "clear", status, 32'h0);

    // Mixed random traffic (R1 R2 R3 R4 R6 R7 R8 R10)
    for (int k = 0; k < 600; k++) begin
      logic [31:0] x;
      logic [2:0]  sel;
      sel = 3'($urandom_range(0, 7));
      case (sel)
        3'd0:    x = 32'h0;
        3'd1:    x = 32'hFFFFFFFF;
        3'd2:    x = $urandom & 32'h01010101;
        3'd3:    x = $urandom | 32'h80008000;
        default: x = $urandom;
      endcase
      step(($urandom_range(0, 3) != 0), 1'($urandom), 4'($urandom), x,
           ($urandom_range(0, 7) == 0), $urandom, "R1/R2/R3/R4/R6/R7/R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule